// File: doc/BRIEF.md
# Mapped Serial Flash Read Engine

This block answers read requests from a memory-mapped port by running a complete read frame on a serial flash bus. It selects the device and shifts out a read opcode, then a programmable number of address bytes. It idles for a programmable number of dummy clocks and then collects the requested number of bytes. Each byte comes back on the response port with a one-cycle valid strobe.

A 32-bit configuration word sets the whole frame. It gives the opcode, the address width, the dummy length and whether data arrives on one line or four. A separate enable input grants the serial bus to this engine. While the enable is low the bus belongs to another controller, and requests are rejected without touching the pins. SCLK runs at half the system clock and idles low. Data is launched on the falling edge and captured on the rising edge.

Top module: `sfr_mmap_reader`

## Requirements
- R1: After reset cs_n_o is 1, sclk_o is 0, rsp_valid_o is 0 and req_ready_o is 1.
- R2: A request accepted while mm_en_i is 0 gives rsp_valid_o and rsp_err_o together in the next cycle. cs_n_o stays 1 and sclk_o stays 0 throughout.
- R3: A frame starts with the opcode from cfg_setup_i[7:0], MSB first, on sd_o[0]. The device samples it on rising SCLK edges, and sd_oe_o is 4'b0001 while the opcode and address are sent.
- R4: Field cfg_setup_i[9:8] = n selects n+1 address bytes. The low n+1 bytes of req_addr_i follow the opcode, most significant byte first.
- R5: After the address come 8*cfg_setup_i[11:10] + cfg_setup_i[28:24] dummy SCLK cycles with sd_oe_o = 0. The data phase follows directly.
- R6: When cfg_setup_i[13:12] is not 3, each data SCLK cycle captures one bit from sd_i[1], MSB first, so 8 cycles make a byte.
- R7: When cfg_setup_i[13:12] is 3, each data SCLK cycle captures one nibble from sd_i[3:0], high nibble first, so 2 cycles make a byte.
- R8: A request returns req_len_i+1 bytes. Each byte is strobed with rsp_valid_o in the cycle after the falling SCLK edge that ends its last data cycle. rsp_last_o marks the final byte.
- R9: cfg_setup_i[23:16] (write opcode) has no effect on the read frame or its data.
- R10: SCLK is clk/2, and the frame takes exactly header+data SCLK cycles. cs_n_o falls the cycle after acceptance and rises the cycle after the final byte strobe, when req_ready_o returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mm_en_i | input | 1 | Bus granted to this engine |
| cfg_setup_i | input | 32 | Frame configuration word |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Engine idle, request accepted |
| req_addr_i | input | ADDR_W | Flash byte address |
| req_len_i | input | LEN_W | Byte count minus one |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_data_o | output | 8 | Returned byte |
| rsp_err_o | output | 1 | Request rejected (engine not enabled) |
| rsp_last_o | output | 1 | Final byte of the request |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| sd_o | output | 4 | Serial data out |
| sd_oe_o | output | 4 | Serial data output enables |
| sd_i | input | 4 | Serial data in |

## Verification
The header takes H = 8 + 8*addr_bytes + dummy cycles, and each byte takes U SCLK cycles (8 single, 2 quad). Byte j is therefore due on the 2*(H+(j+1)*U)+1-th falling clk edge after the request is driven. The bench samples every response at exactly that falling edge and counts any strobe that arrives off schedule. A reject is due one cycle after acceptance, and chip select must rise one cycle after the last strobe. Both are sampled at those exact edges. A flash model counts rising SCLK edges, so the frame length and the opcode, address and dummy contents are checked edge by edge rather than only at the response port.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_DONE
  } sfr_state_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic [1:0] addr_sel;
    logic [1:0] dummy_bytes;
    logic       quad;
    logic [4:0] dummy_bits;
  } sfr_frame_t;

  localparam int unsigned CNT_W = 7;

  function automatic sfr_frame_t sfr_decode(input logic [31:0] word);
    sfr_frame_t f;
    f.opcode      = word[7:0];
    f.addr_sel    = word[9:8];
    f.dummy_bytes = word[11:10];
    f.quad        = (word[13:12] == 2'b11);
    f.dummy_bits  = word[28:24];
    return f;
  endfunction

  function automatic logic [2:0] sfr_addr_bytes(input sfr_frame_t f);
    return 3'(f.addr_sel) + 3'd1;
  endfunction

endpackage

// File: rtl/sfr_frame_ctl.sv
module sfr_frame_ctl
  import sfr_pkg::*;
#(
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  sfr_frame_t       cfg_i,
  input  logic [LEN_W-1:0] len_i,
  output sfr_state_e       state_o,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             byte_done_o,
  output logic             last_o
);

  sfr_state_e       state_q;
  logic             sclk_q;
  logic             cs_n_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] left_q;
  logic             active;
  logic [CNT_W-1:0] addr_cycles;
  logic [CNT_W-1:0] dummy_cycles;
  logic [CNT_W-1:0] unit_reload;

  assign active = (state_q == ST_CMD) || (state_q == ST_ADDR) ||
                  (state_q == ST_DUMMY) || (state_q == ST_DATA);

  assign addr_cycles  = CNT_W'({sfr_addr_bytes(cfg_i), 3'b000}) - CNT_W'(1);
  assign dummy_cycles = CNT_W'({cfg_i.dummy_bytes, 3'b000}) + CNT_W'(cfg_i.dummy_bits);
  assign unit_reload  = cfg_i.quad ? CNT_W'(1) : CNT_W'(7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      cnt_q   <= '0;
      left_q  <= '0;
    end else if (start_i) begin
      state_q <= ST_CMD;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b0;
      cnt_q   <= CNT_W'(7);
      left_q  <= len_i;
    end else if (active) begin
      sclk_q <= ~sclk_q;
      if (sclk_q) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end else begin
          unique case (state_q)
            ST_CMD: begin
              state_q <= ST_ADDR;
              cnt_q   <= addr_cycles;
            end
            ST_ADDR: begin
              if (dummy_cycles != '0) begin
                state_q <= ST_DUMMY;
                cnt_q   <= dummy_cycles - CNT_W'(1);
              end else begin
                state_q <= ST_DATA;
                cnt_q   <= unit_reload;
              end
            end
            ST_DUMMY: begin
              state_q <= ST_DATA;
              cnt_q   <= unit_reload;
            end
            ST_DATA: begin
              if (left_q == '0) begin
                state_q <= ST_DONE;
              end else begin
                left_q <= left_q - LEN_W'(1);
                cnt_q  <= unit_reload;
              end
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end else if (state_q == ST_DONE) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
    end
  end

  assign state_o     = state_q;
  assign sclk_o      = sclk_q;
  assign cs_n_o      = cs_n_q;
  assign rise_o      = active && !sclk_q;
  assign fall_o      = active && sclk_q;
  assign byte_done_o = fall_o && (state_q == ST_DATA) && (cnt_q == '0);
  assign last_o      = (left_q == '0);

endmodule

// File: rtl/sfr_tx_shift.sv
module sfr_tx_shift #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        nbytes_i,
  input  logic              shift_i,
  output logic              bit_o
);

  localparam int unsigned SR_W = ADDR_W + 8;

  logic [SR_W-1:0]   sr_q;
  logic [7:0]        sh_amt;
  logic [ADDR_W-1:0] addr_aligned;

  // left-justify the low address bytes so they leave right after the opcode
  assign sh_amt       = 8'(ADDR_W - 8 * int'(nbytes_i));
  assign addr_aligned = addr_i << sh_amt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= {opcode_i, addr_aligned};
    end else if (shift_i) begin
      sr_q <= {sr_q[SR_W-2:0], 1'b0};
    end
  end

  assign bit_o = sr_q[SR_W-1];

endmodule

// File: rtl/sfr_rx_shift.sv
module sfr_rx_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sample_i,
  input  logic       quad_i,
  input  logic [3:0] sd_i,
  output logic [7:0] byte_o
);

  logic [7:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (sample_i) begin
      if (quad_i) acc_q <= {acc_q[3:0], sd_i};
      else        acc_q <= {acc_q[6:0], sd_i[1]};
    end
  end

  assign byte_o = acc_q;

endmodule

// File: rtl/sfr_mmap_reader.sv
module sfr_mmap_reader
  import sfr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mm_en_i,
  input  logic [31:0]       cfg_setup_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              rsp_valid_o,
  output logic [7:0]        rsp_data_o,
  output logic              rsp_err_o,
  output logic              rsp_last_o,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic [3:0]        sd_o,
  output logic [3:0]        sd_oe_o,
  input  logic [3:0]        sd_i
);

  sfr_frame_t cfg_live;
  sfr_frame_t cfg_q;
  sfr_state_e state;
  logic       accept, start, reject;
  logic       rise, fall, byte_done, last_byte;
  logic       tx_bit, tx_phase;
  logic [7:0] rx_byte;

  assign cfg_live = sfr_decode(cfg_setup_i);
  assign accept   = req_valid_i && req_ready_o;
  assign start    = accept && mm_en_i;
  assign reject   = accept && !mm_en_i;
  assign tx_phase = (state == ST_CMD) || (state == ST_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (start) cfg_q <= cfg_live;
  end

  sfr_frame_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .cfg_i       (cfg_q),
    .len_i       (req_len_i),
    .state_o     (state),
    .sclk_o      (sclk_o),
    .cs_n_o      (cs_n_o),
    .rise_o      (rise),
    .fall_o      (fall),
    .byte_done_o (byte_done),
    .last_o      (last_byte)
  );

  sfr_tx_shift #(.ADDR_W(ADDR_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .opcode_i (cfg_live.opcode),
    .addr_i   (req_addr_i),
    .nbytes_i (sfr_addr_bytes(cfg_live)),
    .shift_i  (fall && tx_phase),
    .bit_o    (tx_bit)
  );

  sfr_rx_shift u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (rise && (state == ST_DATA)),
    .quad_i   (cfg_q.quad),
    .sd_i     (sd_i),
    .byte_o   (rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      rsp_err_o   <= 1'b0;
      rsp_last_o  <= 1'b0;
    end else begin
      rsp_valid_o <= byte_done || reject;
      rsp_err_o   <= reject;
      rsp_last_o  <= byte_done && last_byte;
      if (byte_done) rsp_data_o <= rx_byte;
    end
  end

  assign req_ready_o = (state == ST_IDLE);
  assign sd_o        = {3'b000, tx_phase & tx_bit};
  assign sd_oe_o     = {3'b000, tx_phase};

endmodule

// File: rtl/sfr_mmap_reader_chk.sv
module sfr_mmap_reader_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mm_en_i,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       rsp_valid_o,
  input logic       rsp_err_o,
  input logic       rsp_last_o,
  input logic       sclk_o,
  input logic       cs_n_o,
  input logic [3:0] sd_oe_o
);

  p_reject_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !mm_en_i |=> rsp_valid_o && rsp_err_o);

  p_reject_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> cs_n_o && !sclk_o);

  p_single_oe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_oe_o[3:1] == 3'b000);

  p_last_is_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_o |-> rsp_valid_o && !rsp_err_o);

  p_data_in_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_err_o |-> !cs_n_o);

  p_cs_after_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && mm_en_i |=> !cs_n_o);

  p_sclk_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o);

  p_busy_no_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !req_ready_o);

endmodule

bind sfr_mmap_reader sfr_mmap_reader_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mm_en_i     (mm_en_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .rsp_last_o  (rsp_last_o),
  .sclk_o      (sclk_o),
  .cs_n_o      (cs_n_o),
  .sd_oe_o     (sd_oe_o)
);

// File: tb/sim_sfr_mmap_reader.sv
`timescale 1ns/1ps
module sim_sfr_mmap_reader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mm_en = 1'b0;
  logic [31:0] cfg_setup = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic        rsp_valid, rsp_err, rsp_last;
  logic [7:0]  rsp_data;
  logic        sclk, cs_n;
  logic [3:0]  sd_out, sd_oe;
  logic [3:0]  sd_in = '0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sfr_mmap_reader u0 (
    .clk_i(clk), .rst_ni(rst_n), .mm_en_i(mm_en), .cfg_setup_i(cfg_setup),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_len_i(req_len), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .rsp_err_o(rsp_err), .rsp_last_o(rsp_last), .sclk_o(sclk), .cs_n_o(cs_n),
    .sd_o(sd_out), .sd_oe_o(sd_oe), .sd_i(sd_in)
  );

  // flash model
  int          m_hdr = 8, m_nab = 1, m_upb = 8, m_rises = 0, m_oe_bad = 0;
  logic [7:0]  m_op = '0;
  logic [31:0] m_addr = '0;

  function automatic logic [7:0] flash_byte(input logic [31:0] a);
    logic [7:0] p;
    p = a[7:0] * 8'd7;
    return p ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(negedge cs_n) begin
    m_rises = 0; m_op = '0; m_addr = '0; m_oe_bad = 0;
  end

  always @(posedge cs_n) sd_in = '0;

  always @(posedge sclk) begin
    m_rises++;
    if (m_rises <= 8) m_op = {m_op[6:0], sd_out[0]};
    else if (m_rises <= 8 + 8 * m_nab) m_addr = {m_addr[30:0], sd_out[0]};
    else if (m_rises <= m_hdr && sd_oe != 4'b0000) m_oe_bad++;
  end

  always @(negedge sclk) begin
    if (!cs_n && m_rises >= m_hdr) begin
      int idx;
      logic [7:0] b;
      idx = m_rises - m_hdr;
      b = flash_byte(m_addr + 32'(idx / m_upb));
      if (m_upb == 2) sd_in = (idx % 2 == 0) ? b[7:4] : b[3:0];
      else            sd_in = {2'b00, b[7 - (idx % 8)], 1'b0};
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1", "cs/sclk idle", {cs_n, sclk}, 2'b10);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R1", "valid/ready", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic t_reject;
    int cs_low = 0;
    @(negedge clk);
    mm_en = 1'b0; cfg_setup = 32'h0002_0203; req_addr = 32'h55; req_len = 4'd2;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_err, "R2", "reject strobe", {rsp_valid, rsp_err}, 2'b11);
    for (int i = 0; i < 30; i++) begin
      if (!cs_n || sclk) cs_low++;
      @(negedge clk);
    end
    chk(cs_low == 0 && req_ready, "R2", "bus quiet after reject", cs_low, 0);
  endtask

  task automatic run_read(input logic [31:0] setup, input logic [31:0] addr,
                          input int len, input string dreq, input string tag);
    int nab, hdr, upb, n, got, bad_data, bad_time, bad_last;
    logic [31:0] amask;
    logic [7:0]  act_b, exp_b;
    nab  = int'(setup[9:8]) + 1;
    upb  = (setup[13:12] == 2'b11) ? 2 : 8;
    hdr  = 8 + 8 * nab + 8 * int'(setup[11:10]) + int'(setup[28:24]);
    amask = (nab == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nab)) - 32'h1);
    m_hdr = hdr; m_nab = nab; m_upb = upb;
    got = 0; bad_data = 0; bad_time = 0; bad_last = 0; act_b = '0; exp_b = '0;
    @(negedge clk);
    mm_en = 1'b1; cfg_setup = setup; req_addr = addr; req_len = 4'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (got < len + 1 && n < 5000) begin
      if (rsp_valid) begin
        logic [7:0] e;
        e = flash_byte((addr & amask) + 32'(got));
        if (rsp_data != e && bad_data == 0) begin act_b = rsp_data; exp_b = e; end
        if (rsp_data != e) bad_data++;
        if (n != 2 * (hdr + (got + 1) * upb) + 1) bad_time++;
        if (rsp_last != (got == len)) bad_last++;
        got++;
      end
      if (got < len + 1) begin @(negedge clk); n++; end
    end
    @(negedge clk);
    chk(m_op == setup[7:0], "R3", {tag, " opcode"}, m_op, setup[7:0]);
    chk(m_addr == (addr & amask), "R4", {tag, " address"}, m_addr, addr & amask);
    chk(got == len + 1, "R8", {tag, " byte count"}, got, len + 1);
    chk(bad_data == 0, dreq, {tag, " data"}, act_b, exp_b);
    chk(bad_time == 0, "R5", {tag, " strobe timing"}, bad_time, 0);
    chk(bad_last == 0, "R8", {tag, " last flag"}, bad_last, 0);
    chk(m_oe_bad == 0, "R5", {tag, " dummy not driven"}, m_oe_bad, 0);
    chk(cs_n && req_ready, "R10", {tag, " frame end"}, {cs_n, req_ready}, 2'b11);
    chk(m_rises == hdr + (len + 1) * upb, "R10", {tag, " sclk cycles"}, m_rises, hdr + (len + 1) * upb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_reject;
    run_read(32'h0002_0203, 32'h0012_3456, 3, "R6", "normal");
    run_read(32'h0002_060B, 32'h0000_10F0, 1, "R6", "fast");
    run_read(32'h0002_366B, 32'h0040_0080, 4, "R7", "quad");
    run_read(32'h0300_336B, 32'hDEAD_BEEF, 0, "R7", "quad dummy bits");
    run_read(32'h0500_1003, 32'h00AB_CDEF, 2, "R6", "one addr byte");
    run_read(32'h00FF_0203, 32'h0012_3456, 3, "R9", "write op ignored");
    t_reject;
    run_read(32'h0002_0203, 32'h0000_00FE, 15, "R6", "long");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule